// File: doc/BRIEF.md
# Double-Precision Floating-Point Instruction Decoder

This block is a purely combinational decoder for the 64-bit floating-point instructions of a 32-bit RISC-V core. It takes one 32-bit instruction word and the dynamic rounding mode currently held in the floating-point control/status register. It returns an operation code, the register indices, the sign-extended load/store offset and the rounding mode that actually applies. It also returns write enables that steer the result to the floating-point or the integer register file, a strobe that says whether the accrued exception flags are to be updated, and an illegal-instruction indication.

The decoder sits in the decode stage ahead of an FP execution unit. Execution, memory access and the register files are the job of the surrounding pipeline.

Top module: `fpd_decoder`

## Requirements
- R1: Major opcode 0000111 with funct3 (bits 14:12) 011 decodes as a double load: op 1, FP write, no flag update, offset = bits 31:20 sign-extended to XLEN, rd = bits 11:7, rs1 = bits 19:15.
- R2: Major opcode 0100111 with funct3 011 decodes as a double store: op 2, no register write, no flag update, offset = {bits 31:25, bits 11:7} sign-extended, rs2 = bits 24:20.
- R3: Major opcodes 1000011, 1000111, 1001011 and 1001111 with bits 26:25 equal to 01 decode as op 3, 4, 5 and 6 (multiply-add, multiply-subtract, negated multiply-subtract, negated multiply-add), with rs3 = bits 31:27, FP write and flag update. Any other value of bits 26:25 is illegal.
- R4: Under major opcode 1010011, funct7 (bits 31:25) 0000001, 0000101, 0001001 and 0001101 give op 7 to 10 (add, subtract, multiply, divide); funct7 0101101 with rs2 field 00000 gives op 11 (square root). All write the FP file and update flags.
- R5: funct7 0010001 with funct3 000, 001, 010 gives op 12, 13, 14 (sign inject plain, negated, xor), FP write, no flag update; funct7 0010101 with funct3 000 or 001 gives op 15 (min) or 16 (max), FP write with flag update. These report rounding mode 0.
- R6: funct7 1010001 with funct3 010, 001, 000 gives op 19, 20, 21 (equal, less-than, less-or-equal), integer write with flag update; funct7 1110001 with funct3 001 and rs2 00000 gives op 22 (classify), integer write, no flag update. funct3 of these is not a rounding field.
- R7: Conversions: funct7 0100000/rs2 00001 is op 17 and 0100001/rs2 00000 is op 18 (FP write, no flag update); 1100001 with rs2 00000/00001 is op 23/24 (integer write, flag update); 1101001 with rs2 00000/00001 is op 25/26 (FP write, no flag update).
- R8: For instructions carrying a rounding field (bits 14:12: ops 3 to 11, 17, 18, 23 to 26) a field value 0 to 4 is reported unchanged on the rounding output and value 7 reports the dynamic input.
- R9: A rounding field of 5 or 6, or a field of 7 while the dynamic mode is 5, 6 or 7, makes the instruction illegal.
- R10: Any word matching none of the patterns above, including a wrong fixed rs2, funct3 or format field, raises illegal with op 0, offset 0, rounding output 0 and all write and flag enables low.
- R11: The FP and integer write enables are never high together, and the flag strobe is high only with one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| dyn_rm_i | input | 3 | Dynamic rounding mode from the control/status register |
| op_o | output | 5 | Operation code, 0 when illegal |
| rd_o | output | 5 | Destination index |
| rs1_o | output | 5 | First source index |
| rs2_o | output | 5 | Second source index |
| rs3_o | output | 5 | Third source index (fused ops) |
| imm_o | output | XLEN | Sign-extended load/store offset |
| rm_o | output | 3 | Resolved rounding mode |
| fp_we_o | output | 1 | Result goes to the FP register file |
| int_we_o | output | 1 | Result goes to the integer register file |
| flags_we_o | output | 1 | Accrued exception flags are updated |
| illegal_o | output | 1 | Instruction is not a legal double-precision encoding |

## Verification
The bench builds the decoder with its default XLEN of 32, so the offset's sign extension is seen across the full upper 20 bits for both the contiguous load layout and the split store layout. At that width the scoreboard reaches every legal pattern, each fixed-field violation, and the rounding corners where a static 5 or 6, or a dynamic 5, 6 or 7 behind field value 7, turns a legal opcode illegal, while comparisons with a bad dynamic mode stay legal.

// File: rtl/fpd_decoder.sv
module fpd_decoder #(
  parameter int XLEN = 32
) (
  input  logic [31:0]     instr_i,
  input  logic [2:0]      dyn_rm_i,
  output logic [4:0]      op_o,
  output logic [4:0]      rd_o,
  output logic [4:0]      rs1_o,
  output logic [4:0]      rs2_o,
  output logic [4:0]      rs3_o,
  output logic [XLEN-1:0] imm_o,
  output logic [2:0]      rm_o,
  output logic            fp_we_o,
  output logic            int_we_o,
  output logic            flags_we_o,
  output logic            illegal_o
);

  localparam logic [6:0] OPC_LD   = 7'b0000111;
  localparam logic [6:0] OPC_ST   = 7'b0100111;
  localparam logic [6:0] OPC_MA   = 7'b1000011;
  localparam logic [6:0] OPC_MS   = 7'b1000111;
  localparam logic [6:0] OPC_NMS  = 7'b1001011;
  localparam logic [6:0] OPC_NMA  = 7'b1001111;
  localparam logic [6:0] OPC_ARI  = 7'b1010011;
  localparam int         EXT      = XLEN - 12;

  localparam logic [4:0] K_NONE = 5'd0,  K_LD = 5'd1,  K_ST = 5'd2,
                         K_MA   = 5'd3,  K_MS = 5'd4,  K_NMS = 5'd5, K_NMA = 5'd6,
                         K_ADD  = 5'd7,  K_SUB = 5'd8, K_MUL = 5'd9, K_DIV = 5'd10,
                         K_SQRT = 5'd11, K_SJ = 5'd12, K_SJN = 5'd13, K_SJX = 5'd14,
                         K_MIN  = 5'd15, K_MAX = 5'd16, K_D2S = 5'd17, K_S2D = 5'd18,
                         K_EQ   = 5'd19, K_LT = 5'd20, K_LE = 5'd21, K_CLS = 5'd22,
                         K_D2I  = 5'd23, K_D2U = 5'd24, K_I2D = 5'd25, K_U2D = 5'd26;

  wire [6:0] opc  = instr_i[6:0];
  wire [2:0] f3   = instr_i[14:12];
  wire [6:0] f7   = instr_i[31:25];
  wire [4:0] sub  = instr_i[24:20];

  logic [4:0] kind;
  logic       to_fp, to_int, fl, uses_rm;
  logic [1:0] imm_sel;

  always_comb begin
    kind = K_NONE; to_fp = 1'b0; to_int = 1'b0; fl = 1'b0; uses_rm = 1'b0; imm_sel = 2'd0;
    unique case (opc)
      OPC_LD: if (f3 == 3'b011) begin kind = K_LD; to_fp = 1'b1; imm_sel = 2'd1; end
      OPC_ST: if (f3 == 3'b011) begin kind = K_ST; imm_sel = 2'd2; end
      OPC_MA, OPC_MS, OPC_NMS, OPC_NMA:
        if (instr_i[26:25] == 2'b01) begin
          to_fp = 1'b1; fl = 1'b1; uses_rm = 1'b1;
          case (opc)
            OPC_MA:  kind = K_MA;
            OPC_MS:  kind = K_MS;
            OPC_NMS: kind = K_NMS;
            default: kind = K_NMA;
          endcase
        end
      OPC_ARI: begin
        case (f7)
          7'b0000001: begin kind = K_ADD; to_fp = 1'b1; fl = 1'b1; uses_rm = 1'b1; end
          7'b0000101: begin kind = K_SUB; to_fp = 1'b1; fl = 1'b1; uses_rm = 1'b1; end
          7'b0001001: begin kind = K_MUL; to_fp = 1'b1; fl = 1'b1; uses_rm = 1'b1; end
          7'b0001101: begin kind = K_DIV; to_fp = 1'b1; fl = 1'b1; uses_rm = 1'b1; end
          7'b0101101:
            if (sub == 5'd0) begin kind = K_SQRT; to_fp = 1'b1; fl = 1'b1; uses_rm = 1'b1; end
          7'b0010001: begin
            to_fp = (f3 <= 3'b010);
            case (f3)
              3'b000:  kind = K_SJ;
              3'b001:  kind = K_SJN;
              3'b010:  kind = K_SJX;
              default: kind = K_NONE;
            endcase
          end
          7'b0010101:
            if (f3 <= 3'b001) begin
              kind = f3[0] ? K_MAX : K_MIN; to_fp = 1'b1; fl = 1'b1;
            end
          7'b0100000:
            if (sub == 5'd1) begin kind = K_D2S; to_fp = 1'b1; uses_rm = 1'b1; end
          7'b0100001:
            if (sub == 5'd0) begin kind = K_S2D; to_fp = 1'b1; uses_rm = 1'b1; end
          7'b1010001: begin
            to_int = (f3 <= 3'b010); fl = (f3 <= 3'b010);
            case (f3)
              3'b010:  kind = K_EQ;
              3'b001:  kind = K_LT;
              3'b000:  kind = K_LE;
              default: kind = K_NONE;
            endcase
          end
          7'b1110001:
            if (f3 == 3'b001 && sub == 5'd0) begin kind = K_CLS; to_int = 1'b1; end
          7'b1100001:
            if (sub <= 5'd1) begin
              kind = sub[0] ? K_D2U : K_D2I; to_int = 1'b1; fl = 1'b1; uses_rm = 1'b1;
            end
          7'b1101001:
            if (sub <= 5'd1) begin
              kind = sub[0] ? K_U2D : K_I2D; to_fp = 1'b1; uses_rm = 1'b1;
            end
          default: kind = K_NONE;
        endcase
      end
      default: kind = K_NONE;
    endcase
  end

  wire [2:0] rm_eff = (f3 == 3'b111) ? dyn_rm_i : f3;
  wire       rm_bad = uses_rm && (rm_eff >= 3'd5);
  wire       bad    = (kind == K_NONE) || rm_bad;

  assign illegal_o  = bad;
  assign op_o       = bad ? K_NONE : kind;
  assign fp_we_o    = !bad && to_fp;
  assign int_we_o   = !bad && to_int;
  assign flags_we_o = !bad && fl;
  assign rm_o       = (!bad && uses_rm) ? rm_eff : 3'd0;

  assign rd_o  = instr_i[11:7];
  assign rs1_o = instr_i[19:15];
  assign rs2_o = instr_i[24:20];
  assign rs3_o = instr_i[31:27];

  always_comb begin
    if (bad)
      imm_o = '0;
    else if (imm_sel == 2'd1)
      imm_o = {{EXT{instr_i[31]}}, instr_i[31:20]};
    else if (imm_sel == 2'd2)
      imm_o = {{EXT{instr_i[31]}}, instr_i[31:25], instr_i[11:7]};
    else
      imm_o = '0;
  end

  always_comb begin
    p_one_file_r11:     assert (!(fp_we_o && int_we_o));
    p_flag_needs_wr_r11: assert (!flags_we_o || fp_we_o || int_we_o);
    p_illegal_quiet_r10: assert (!illegal_o || (op_o == 5'd0 && !fp_we_o && !int_we_o && !flags_we_o));
    p_rm_in_range_r9:   assert (illegal_o || rm_o < 3'd5);
    p_store_no_write_r2: assert (op_o != 5'd2 || (!fp_we_o && !int_we_o));
  end

endmodule

// File: tb/test_fpd_decoder.sv
module test_fpd_decoder;
  localparam int XLEN = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [31:0]     instr;
  logic [2:0]      dyn;
  logic [4:0]      op, rd, rs1, rs2, rs3;
  logic [XLEN-1:0] imm;
  logic [2:0]      rm;
  logic            fpw, intw, flw, ill;

  fpd_decoder #(.XLEN(XLEN)) i_fpd_decoder (
    .instr_i(instr), .dyn_rm_i(dyn), .op_o(op), .rd_o(rd), .rs1_o(rs1), .rs2_o(rs2),
    .rs3_o(rs3), .imm_o(imm), .rm_o(rm), .fp_we_o(fpw), .int_we_o(intw),
    .flags_we_o(flw), .illegal_o(ill));

  typedef struct {
    string       tag;
    logic [31:0] word;
    logic [4:0]  op;
    logic        fpw, intw, flw, ill;
    logic [2:0]  rm;
    logic [31:0] imm;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  function automatic logic [31:0] rt(logic [6:0] f7, logic [4:0] s2, logic [4:0] s1,
                                     logic [2:0] f3, logic [4:0] d, logic [6:0] opc);
    return {f7, s2, s1, f3, d, opc};
  endfunction

  function automatic logic [31:0] st(logic [11:0] im, logic [4:0] s2, logic [4:0] s1);
    return {im[11:5], s2, s1, 3'b011, im[4:0], 7'b0100111};
  endfunction

  task automatic go(string tag, logic [31:0] w, logic [2:0] d, logic [4:0] eop,
                    logic efp, logic eint, logic efl, logic eill, logic [2:0] erm,
                    logic [31:0] eimm);
    exp_t e;
    @(posedge clk);
    #1;
    instr = w; dyn = d;
    e.tag = tag; e.word = w; e.op = eop; e.fpw = efp; e.intw = eint; e.flw = efl;
    e.ill = eill; e.rm = erm; e.imm = eimm;
    q.push_back(e);
  endtask

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        cmp(e.tag, "op",    32'(op),   32'(e.op));
        cmp(e.tag, "fp_we", 32'(fpw),  32'(e.fpw));
        cmp(e.tag, "int_we",32'(intw), 32'(e.intw));
        cmp(e.tag, "flags", 32'(flw),  32'(e.flw));
        cmp(e.tag, "illegal",32'(ill), 32'(e.ill));
        cmp(e.tag, "rm",    32'(rm),   32'(e.rm));
        cmp(e.tag, "imm",   imm,       e.imm);
        cmp(e.tag, "rd",    32'(rd),   32'(e.word[11:7]));
        cmp(e.tag, "rs1",   32'(rs1),  32'(e.word[19:15]));
        cmp(e.tag, "rs2",   32'(rs2),  32'(e.word[24:20]));
        cmp(e.tag, "rs3",   32'(rs3),  32'(e.word[31:27]));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  localparam logic [6:0] AR = 7'b1010011;

  initial begin
    instr = 32'h0; dyn = 3'd0;
    // reset-like idle state: all-zero word is illegal (R10)
    go("R10", 32'h0, 3'd0, 5'd0, 0, 0, 0, 1, 3'd0, 32'h0);
    // loads (R1)
    go("R1", {12'hFF8, 5'd5, 3'b011, 5'd7, 7'b0000111}, 3'd0, 5'd1, 1, 0, 0, 0, 3'd0, 32'hFFFF_FFF8);
    go("R1", {12'h123, 5'd31, 3'b011, 5'd1, 7'b0000111}, 3'd6, 5'd1, 1, 0, 0, 0, 3'd0, 32'h0000_0123);
    go("R10", {12'h123, 5'd31, 3'b010, 5'd1, 7'b0000111}, 3'd0, 5'd0, 0, 0, 0, 1, 3'd0, 32'h0);
    // stores (R2)
    go("R2", st(12'h7E5, 5'd9, 5'd3), 3'd0, 5'd2, 0, 0, 0, 0, 3'd0, 32'h0000_07E5);
    go("R2", st(12'h800, 5'd1, 5'd2), 3'd0, 5'd2, 0, 0, 0, 0, 3'd0, 32'hFFFF_F800);
    // fused (R3, R8)
    go("R3", {5'd9, 2'b01, 5'd4, 5'd2, 3'd0, 5'd6, 7'b1000011}, 3'd3, 5'd3, 1, 0, 1, 0, 3'd0, 32'h0);
    go("R8", {5'd17,2'b01, 5'd4, 5'd2, 3'd7, 5'd6, 7'b1000111}, 3'd2, 5'd4, 1, 0, 1, 0, 3'd2, 32'h0);
    go("R3", {5'd1, 2'b01, 5'd4, 5'd2, 3'd1, 5'd6, 7'b1001011}, 3'd0, 5'd5, 1, 0, 1, 0, 3'd1, 32'h0);
    go("R3", {5'd30,2'b01, 5'd4, 5'd2, 3'd4, 5'd6, 7'b1001111}, 3'd0, 5'd6, 1, 0, 1, 0, 3'd4, 32'h0);
    go("R3", {5'd9, 2'b00, 5'd4, 5'd2, 3'd0, 5'd6, 7'b1000011}, 3'd0, 5'd0, 0, 0, 0, 1, 3'd0, 32'h0);
    // arithmetic (R4, R8, R9)
    go("R4", rt(7'b0000001, 5'd3, 5'd4, 3'd3, 5'd5, AR), 3'd0, 5'd7, 1, 0, 1, 0, 3'd3, 32'h0);
    go("R8", rt(7'b0000101, 5'd3, 5'd4, 3'd7, 5'd5, AR), 3'd4, 5'd8, 1, 0, 1, 0, 3'd4, 32'h0);
    go("R4", rt(7'b0001001, 5'd3, 5'd4, 3'd2, 5'd5, AR), 3'd0, 5'd9, 1, 0, 1, 0, 3'd2, 32'h0);
    go("R9", rt(7'b0001001, 5'd3, 5'd4, 3'd5, 5'd5, AR), 3'd0, 5'd0, 0, 0, 0, 1, 3'd0, 32'h0);
    go("R9", rt(7'b0001101, 5'd3, 5'd4, 3'd6, 5'd5, AR), 3'd0, 5'd0, 0, 0, 0, 1, 3'd0, 32'h0);
    go("R9", rt(7'b0001101, 5'd3, 5'd4, 3'd7, 5'd5, AR), 3'd6, 5'd0, 0, 0, 0, 1, 3'd0, 32'h0);
    go("R9", rt(7'b0001101, 5'd3, 5'd4, 3'd7, 5'd5, AR), 3'd7, 5'd0, 0, 0, 0, 1, 3'd0, 32'h0);
    go("R4", rt(7'b0001101, 5'd3, 5'd4, 3'd0, 5'd5, AR), 3'd7, 5'd10, 1, 0, 1, 0, 3'd0, 32'h0);
    go("R4", rt(7'b0101101, 5'd0, 5'd4, 3'd1, 5'd5, AR), 3'd0, 5'd11, 1, 0, 1, 0, 3'd1, 32'h0);
    go("R10", rt(7'b0101101, 5'd3, 5'd4, 3'd1, 5'd5, AR), 3'd0, 5'd0, 0, 0, 0, 1, 3'd0, 32'h0);
    // sign inject, min/max (R5)
    go("R5", rt(7'b0010001, 5'd3, 5'd4, 3'd0, 5'd5, AR), 3'd7, 5'd12, 1, 0, 0, 0, 3'd0, 32'h0);
    go("R5", rt(7'b0010001, 5'd3, 5'd4, 3'd1, 5'd5, AR), 3'd0, 5'd13, 1, 0, 0, 0, 3'd0, 32'h0);
    go("R5", rt(7'b0010001, 5'd3, 5'd4, 3'd2, 5'd5, AR), 3'd0, 5'd14, 1, 0, 0, 0, 3'd0, 32'h0);
    go("R10", rt(7'b0010001, 5'd3, 5'd4, 3'd3, 5'd5, AR), 3'd0, 5'd0, 0, 0, 0, 1, 3'd0, 32'h0);
    go("R5", rt(7'b0010101, 5'd3, 5'd4, 3'd0, 5'd5, AR), 3'd0, 5'd15, 1, 0, 1, 0, 3'd0, 32'h0);
    go("R5", rt(7'b0010101, 5'd3, 5'd4, 3'd1, 5'd5, AR), 3'd0, 5'd16, 1, 0, 1, 0, 3'd0, 32'h0);
    // compare, classify (R6)
    go("R6", rt(7'b1010001, 5'd3, 5'd4, 3'd2, 5'd5, AR), 3'd7, 5'd19, 0, 1, 1, 0, 3'd0, 32'h0);
    go("R6", rt(7'b1010001, 5'd3, 5'd4, 3'd1, 5'd5, AR), 3'd0, 5'd20, 0, 1, 1, 0, 3'd0, 32'h0);
    go("R6", rt(7'b1010001, 5'd3, 5'd4, 3'd0, 5'd5, AR), 3'd0, 5'd21, 0, 1, 1, 0, 3'd0, 32'h0);
    go("R10", rt(7'b1010001, 5'd3, 5'd4, 3'd3, 5'd5, AR), 3'd0, 5'd0, 0, 0, 0, 1, 3'd0, 32'h0);
    go("R6", rt(7'b1110001, 5'd0, 5'd4, 3'd1, 5'd5, AR), 3'd0, 5'd22, 0, 1, 0, 0, 3'd0, 32'h0);
    go("R10", rt(7'b1110001, 5'd0, 5'd4, 3'd0, 5'd5, AR), 3'd0, 5'd0, 0, 0, 0, 1, 3'd0, 32'h0);
    // conversions (R7)
    go("R7", rt(7'b0100000, 5'd1, 5'd4, 3'd2, 5'd5, AR), 3'd0, 5'd17, 1, 0, 0, 0, 3'd2, 32'h0);
    go("R10", rt(7'b0100000, 5'd0, 5'd4, 3'd2, 5'd5, AR), 3'd0, 5'd0, 0, 0, 0, 1, 3'd0, 32'h0);
    go("R7", rt(7'b0100001, 5'd0, 5'd4, 3'd7, 5'd5, AR), 3'd1, 5'd18, 1, 0, 0, 0, 3'd1, 32'h0);
    go("R7", rt(7'b1100001, 5'd0, 5'd4, 3'd1, 5'd5, AR), 3'd0, 5'd23, 0, 1, 1, 0, 3'd1, 32'h0);
    go("R7", rt(7'b1100001, 5'd1, 5'd4, 3'd0, 5'd5, AR), 3'd0, 5'd24, 0, 1, 1, 0, 3'd0, 32'h0);
    go("R10", rt(7'b1100001, 5'd2, 5'd4, 3'd0, 5'd5, AR), 3'd0, 5'd0, 0, 0, 0, 1, 3'd0, 32'h0);
    go("R7", rt(7'b1101001, 5'd0, 5'd4, 3'd4, 5'd5, AR), 3'd0, 5'd25, 1, 0, 0, 0, 3'd4, 32'h0);
    go("R7", rt(7'b1101001, 5'd1, 5'd4, 3'd3, 5'd5, AR), 3'd0, 5'd26, 1, 0, 0, 0, 3'd3, 32'h0);
    go("R9", rt(7'b1101001, 5'd1, 5'd4, 3'd7, 5'd5, AR), 3'd5, 5'd0, 0, 0, 0, 1, 3'd0, 32'h0);
    // unmatched (R10, R11 checked through the enables above)
    go("R10", rt(7'b0000000, 5'd3, 5'd4, 3'd0, 5'd5, AR), 3'd0, 5'd0, 0, 0, 0, 1, 3'd0, 32'h0);
    go("R10", rt(7'b0000001, 5'd3, 5'd4, 3'd0, 5'd5, 7'b0110011), 3'd0, 5'd0, 0, 0, 0, 1, 3'd0, 32'h0);
    go("R11", rt(7'b1100001, 5'd0, 5'd4, 3'd0, 5'd5, AR), 3'd0, 5'd23, 0, 1, 1, 0, 3'd0, 32'h0);
    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule